// File: doc/BRIEF.md
# RV32I Instruction Decoder

This block is the purely combinational decode stage of a single-issue 32-bit integer core. It takes one 32-bit instruction word and returns four things. The first is a class code naming the instruction's role. The second is an operation code for the arithmetic unit. The third is a comparison code for the branch unit. The last is the three register numbers, the write and read strobes that later stages act on, and a 32-bit immediate that has already been assembled for the word's encoding format and sign-extended.

The recognised classes are register-register arithmetic, register-immediate arithmetic, conditional branch, jump-and-link, register-indirect jump, load-upper-immediate, 32-bit load and 32-bit store. Any other word is classed as unsupported. An unsupported word raises no write or read strobe, so the datapath can act on it as a no-op or trap on it. Register access, execution and sub-word memory accesses belong to other blocks.

Top module: `instr_decoder`

## Requirements
- R1: `rd_o`, `rs1_o` and `rs2_o` always show instruction bits [11:7], [19:15] and [24:20], whatever the class.
- R2: The class output uses these codes: 0 reg-reg ALU (opcode 0110011), 1 reg-imm ALU (0010011), 2 branch (1100011), 3 jump-and-link (1101111), 4 indirect jump (1100111), 5 load-upper (0110111), 6 load (0000011), 7 store (0100011), 8 unsupported. Opcode is bits [6:0], funct3 bits [14:12], funct7 bits [31:25].
- R3: Reg-reg words with funct7 0000000 map funct3 to the ALU codes 000 add=0, 001 sll=2, 010 slt=3, 011 sltu=4, 100 xor=5, 101 srl=6, 110 or=8, 111 and=9. Funct7 0100000 selects sub=1 for funct3 000 and sra=7 for funct3 101. Any other funct7/funct3 pair is unsupported.
- R4: Reg-imm words use the same funct3 map, but bit 30 never turns add into subtract. For funct3 101, funct7 0100000 gives sra and 0000000 gives srl. Funct3 001 needs funct7 0000000. Other shift funct7 values are unsupported. The shift amount is the low five bits of the immediate.
- R5: Reg-imm, load and indirect-jump words output bits [31:20] sign-extended.
- R6: Store words output {bits[31:25], bits[11:7]} sign-extended.
- R7: Branch words output the 13-bit offset {b31, b7, b30:25, b11:8, 0} sign-extended. Funct3 maps to the compare codes 000 eq=0, 001 ne=1, 100 lt=2, 101 ge=3, 110 ltu=4, 111 geu=5. Funct3 010 and 011 are unsupported.
- R8: Jump-and-link words output {b31, b19:12, b20, b30:21, 0} sign-extended.
- R9: Load-upper words output bits [31:12] followed by twelve zeros.
- R10: Load and store need funct3 010, and indirect jump needs funct3 000, or the word is unsupported. Load, store and indirect jump select ALU add.
- R11: Register write is raised for reg-reg, reg-imm, jump-and-link, indirect jump, load-upper and load. Memory write is raised only for store, and memory read only for load.
- R12: Unsupported words give class 8, zero immediate, ALU add, compare code 0 and no strobes. Non-branch words give compare code 0, and reg-reg words give a zero immediate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word to decode |
| kind_o | output | 4 | Instruction class code |
| alu_fn_o | output | 4 | Arithmetic unit operation code |
| br_fn_o | output | 3 | Branch comparison code |
| rd_o | output | 5 | Destination register number |
| rs1_o | output | 5 | First source register number |
| rs2_o | output | 5 | Second source register number |
| imm_o | output | 32 | Assembled, sign-extended immediate |
| reg_we_o | output | 1 | Register-file write strobe |
| mem_we_o | output | 1 | Data-memory write strobe |
| mem_re_o | output | 1 | Data-memory read strobe |

## Verification
The bench gives an ADDI with bit 30 set. A decoder that shared the reg-reg add/subtract rule would return subtract for it. Offsets are driven at their most negative and most positive values and with bit 11 set alone, so a misplaced scattered bit or a missed sign bit in the branch or jump immediate shows up as a wrong constant. Shift encodings with a bad funct7 are driven, and so are sub-word loads and stores and the unused branch conditions. A decoder that let these through would raise a write strobe on a word that should be inert.

// File: rtl/rvdec_pkg.sv
package rvdec_pkg;

    localparam int XLEN   = 32;
    localparam int REG_W  = 5;
    localparam int OPC_W  = 7;
    localparam int F3_W   = 3;
    localparam int F7_W   = 7;
    localparam int KIND_W = 4;
    localparam int ALU_W  = 4;
    localparam int BR_W   = 3;

    localparam int RD_LSB  = OPC_W;
    localparam int F3_LSB  = RD_LSB + REG_W;
    localparam int RS1_LSB = F3_LSB + F3_W;
    localparam int RS2_LSB = RS1_LSB + REG_W;
    localparam int F7_LSB  = RS2_LSB + REG_W;

    localparam logic [OPC_W-1:0] OPC_OP     = 7'b0110011;
    localparam logic [OPC_W-1:0] OPC_OPIMM  = 7'b0010011;
    localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
    localparam logic [OPC_W-1:0] OPC_JAL    = 7'b1101111;
    localparam logic [OPC_W-1:0] OPC_JALR   = 7'b1100111;
    localparam logic [OPC_W-1:0] OPC_LUI    = 7'b0110111;
    localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
    localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;

    localparam logic [F7_W-1:0] F7_BASE = 7'b0000000;
    localparam logic [F7_W-1:0] F7_ALT  = 7'b0100000;
    localparam logic [F3_W-1:0] F3_WORD = 3'b010;

    typedef enum logic [KIND_W-1:0] {
        K_OP     = 4'd0,
        K_OPIMM  = 4'd1,
        K_BRANCH = 4'd2,
        K_JAL    = 4'd3,
        K_JALR   = 4'd4,
        K_LUI    = 4'd5,
        K_LOAD   = 4'd6,
        K_STORE  = 4'd7,
        K_UNSUP  = 4'd8
    } kind_e;

    typedef enum logic [ALU_W-1:0] {
        ALU_ADD  = 4'd0,
        ALU_SUB  = 4'd1,
        ALU_SLL  = 4'd2,
        ALU_SLT  = 4'd3,
        ALU_SLTU = 4'd4,
        ALU_XOR  = 4'd5,
        ALU_SRL  = 4'd6,
        ALU_SRA  = 4'd7,
        ALU_OR   = 4'd8,
        ALU_AND  = 4'd9
    } alu_e;

    typedef enum logic [BR_W-1:0] {
        BR_EQ  = 3'd0,
        BR_NE  = 3'd1,
        BR_LT  = 3'd2,
        BR_GE  = 3'd3,
        BR_LTU = 3'd4,
        BR_GEU = 3'd5
    } br_e;

    typedef enum logic [2:0] {
        FMT_NONE,
        FMT_I,
        FMT_S,
        FMT_B,
        FMT_J,
        FMT_U
    } imm_fmt_e;

    typedef struct packed {
        logic [F7_W-1:0]  f7;
        logic [REG_W-1:0] rs2;
        logic [REG_W-1:0] rs1;
        logic [F3_W-1:0]  f3;
        logic [REG_W-1:0] rd;
        logic [OPC_W-1:0] opcode;
    } fields_t;

    typedef struct packed {
        kind_e    kind;
        alu_e     alu;
        br_e      br;
        imm_fmt_e fmt;
        logic     reg_we;
        logic     mem_we;
        logic     mem_re;
    } ctrl_t;

    // funct3 -> ALU operation; 'alt' picks subtract / arithmetic shift
    function automatic alu_e alu_of_f3(input logic [F3_W-1:0] f3, input logic alt);
        alu_e r;
        case (f3)
            3'b000:  r = alt ? ALU_SUB : ALU_ADD;
            3'b001:  r = ALU_SLL;
            3'b010:  r = ALU_SLT;
            3'b011:  r = ALU_SLTU;
            3'b100:  r = ALU_XOR;
            3'b101:  r = alt ? ALU_SRA : ALU_SRL;
            3'b110:  r = ALU_OR;
            default: r = ALU_AND;
        endcase
        return r;
    endfunction

    function automatic br_e br_of_f3(input logic [F3_W-1:0] f3);
        br_e r;
        case (f3)
            3'b001:  r = BR_NE;
            3'b100:  r = BR_LT;
            3'b101:  r = BR_GE;
            3'b110:  r = BR_LTU;
            3'b111:  r = BR_GEU;
            default: r = BR_EQ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rvdec_fields.sv
module rvdec_fields
    import rvdec_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output fields_t         fields
);
    always_comb begin
        fields.opcode = instr[OPC_W-1:0];
        fields.rd     = instr[RD_LSB +: REG_W];
        fields.f3     = instr[F3_LSB +: F3_W];
        fields.rs1    = instr[RS1_LSB +: REG_W];
        fields.rs2    = instr[RS2_LSB +: REG_W];
        fields.f7     = instr[F7_LSB +: F7_W];
    end
endmodule

// File: rtl/rvdec_ctrl.sv
module rvdec_ctrl
    import rvdec_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    input  logic [F3_W-1:0]  f3,
    input  logic [F7_W-1:0]  f7,
    output ctrl_t            ctrl
);
    logic op_legal;
    logic opimm_legal;
    logic f3_is_shift_r;

    assign f3_is_shift_r = (f3 == 3'b101);

    // reg-reg: base funct7 for all, alternate only for add/sub and right shifts
    assign op_legal = (f7 == F7_BASE) ||
                      ((f7 == F7_ALT) && ((f3 == 3'b000) || f3_is_shift_r));

    // reg-imm: only the shift encodings constrain the upper bits
    always_comb begin
        case (f3)
            3'b001:  opimm_legal = (f7 == F7_BASE);
            3'b101:  opimm_legal = (f7 == F7_BASE) || (f7 == F7_ALT);
            default: opimm_legal = 1'b1;
        endcase
    end

    always_comb begin
        ctrl        = '0;
        ctrl.kind   = K_UNSUP;
        ctrl.alu    = ALU_ADD;
        ctrl.br     = BR_EQ;
        ctrl.fmt    = FMT_NONE;
        case (opcode)
            OPC_OP: if (op_legal) begin
                ctrl.kind   = K_OP;
                ctrl.alu    = alu_of_f3(f3, f7[5]);
                ctrl.reg_we = 1'b1;
            end
            OPC_OPIMM: if (opimm_legal) begin
                ctrl.kind   = K_OPIMM;
                ctrl.alu    = alu_of_f3(f3, f3_is_shift_r && f7[5]);
                ctrl.fmt    = FMT_I;
                ctrl.reg_we = 1'b1;
            end
            OPC_BRANCH: if (f3[2:1] != 2'b01) begin
                ctrl.kind = K_BRANCH;
                ctrl.br   = br_of_f3(f3);
                ctrl.fmt  = FMT_B;
            end
            OPC_JAL: begin
                ctrl.kind   = K_JAL;
                ctrl.fmt    = FMT_J;
                ctrl.reg_we = 1'b1;
            end
            OPC_JALR: if (f3 == 3'b000) begin
                ctrl.kind   = K_JALR;
                ctrl.fmt    = FMT_I;
                ctrl.reg_we = 1'b1;
            end
            OPC_LUI: begin
                ctrl.kind   = K_LUI;
                ctrl.fmt    = FMT_U;
                ctrl.reg_we = 1'b1;
            end
            OPC_LOAD: if (f3 == F3_WORD) begin
                ctrl.kind   = K_LOAD;
                ctrl.fmt    = FMT_I;
                ctrl.reg_we = 1'b1;
                ctrl.mem_re = 1'b1;
            end
            OPC_STORE: if (f3 == F3_WORD) begin
                ctrl.kind   = K_STORE;
                ctrl.fmt    = FMT_S;
                ctrl.mem_we = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rvdec_imm.sv
module rvdec_imm
    import rvdec_pkg::*;
(
    input  logic [XLEN-1:OPC_W] ibits,
    input  imm_fmt_e            fmt,
    output logic [XLEN-1:0]     imm
);
    localparam int MSB   = XLEN - 1;
    localparam int SX_I  = XLEN - 12;
    localparam int SX_B  = XLEN - 13;
    localparam int SX_J  = XLEN - 21;
    localparam int U_LOW = 12;

    logic sgn;
    assign sgn = ibits[MSB];

    always_comb begin
        case (fmt)
            FMT_I:   imm = {{SX_I{sgn}}, ibits[MSB:20]};
            FMT_S:   imm = {{SX_I{sgn}}, ibits[MSB:25], ibits[11:7]};
            FMT_B:   imm = {{SX_B{sgn}}, sgn, ibits[7], ibits[30:25], ibits[11:8], 1'b0};
            FMT_J:   imm = {{SX_J{sgn}}, sgn, ibits[19:12], ibits[20], ibits[30:21], 1'b0};
            FMT_U:   imm = {ibits[MSB:U_LOW], {U_LOW{1'b0}}};
            default: imm = '0;
        endcase
    end
endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
    import rvdec_pkg::*;
(
    input  logic [XLEN-1:0]   instr_i,
    output logic [KIND_W-1:0] kind_o,
    output logic [ALU_W-1:0]  alu_fn_o,
    output logic [BR_W-1:0]   br_fn_o,
    output logic [REG_W-1:0]  rd_o,
    output logic [REG_W-1:0]  rs1_o,
    output logic [REG_W-1:0]  rs2_o,
    output logic [XLEN-1:0]   imm_o,
    output logic              reg_we_o,
    output logic              mem_we_o,
    output logic              mem_re_o
);
    fields_t fields;
    ctrl_t   ctrl;

    rvdec_fields i_fields (
        .instr  (instr_i),
        .fields (fields)
    );

    rvdec_ctrl i_ctrl (
        .opcode (fields.opcode),
        .f3     (fields.f3),
        .f7     (fields.f7),
        .ctrl   (ctrl)
    );

    rvdec_imm i_imm (
        .ibits (instr_i[XLEN-1:OPC_W]),
        .fmt   (ctrl.fmt),
        .imm   (imm_o)
    );

    assign kind_o   = ctrl.kind;
    assign alu_fn_o = ctrl.alu;
    assign br_fn_o  = ctrl.br;
    assign rd_o     = fields.rd;
    assign rs1_o    = fields.rs1;
    assign rs2_o    = fields.rs2;
    assign reg_we_o = ctrl.reg_we;
    assign mem_we_o = ctrl.mem_we;
    assign mem_re_o = ctrl.mem_re;
endmodule

// File: rtl/instr_decoder_chk.sv
module instr_decoder_chk
    import rvdec_pkg::*;
(
    input logic [XLEN-1:0]   instr_i,
    input logic [KIND_W-1:0] kind_o,
    input logic [ALU_W-1:0]  alu_fn_o,
    input logic [BR_W-1:0]   br_fn_o,
    input logic [REG_W-1:0]  rd_o,
    input logic [REG_W-1:0]  rs1_o,
    input logic [REG_W-1:0]  rs2_o,
    input logic [XLEN-1:0]   imm_o,
    input logic              reg_we_o,
    input logic              mem_we_o,
    input logic              mem_re_o
);
    always_comb begin
        if (!$isunknown(instr_i)) begin
            a_r1_reg_fields: assert (rd_o == instr_i[11:7] && rs1_o == instr_i[19:15]
                                     && rs2_o == instr_i[24:20]);
            if (kind_o == K_UNSUP) begin
                a_r12_unsup_quiet: assert (!reg_we_o && !mem_we_o && !mem_re_o && imm_o == '0);
            end
            if (kind_o != K_BRANCH) begin
                a_r12_br_idle: assert (br_fn_o == BR_EQ);
            end
            if (kind_o == K_BRANCH) begin
                a_r7_branch_even: assert (imm_o[0] == 1'b0 && !reg_we_o && !mem_we_o
                                          && br_fn_o <= BR_GEU);
            end
            if (kind_o == K_JAL) begin
                a_r8_jump_even: assert (imm_o[0] == 1'b0 && reg_we_o);
            end
            if (kind_o == K_LUI) begin
                a_r9_upper_low_zero: assert (imm_o[11:0] == 12'h000);
            end
            if (kind_o == K_LOAD) begin
                a_r10_load_word: assert (instr_i[14:12] == F3_WORD && mem_re_o && !mem_we_o
                                         && alu_fn_o == ALU_ADD);
            end
            if (kind_o == K_STORE) begin
                a_r11_store_no_reg: assert (!reg_we_o && mem_we_o && !mem_re_o);
            end
        end
    end
endmodule

bind instr_decoder instr_decoder_chk i_chk (.*);

// File: tb/test_instr_decoder.sv
`timescale 1ns/1ps
module test_instr_decoder;
    import rvdec_pkg::*;

    logic clk = 1'b0;
    logic rst;
    always #4 clk = ~clk;

    logic [31:0] instr;
    logic [3:0]  kind;
    logic [3:0]  alu_fn;
    logic [2:0]  br_fn;
    logic [4:0]  rd, rs1, rs2;
    logic [31:0] imm;
    logic        reg_we, mem_we, mem_re;

    instr_decoder i_instr_decoder (
        .instr_i  (instr),
        .kind_o   (kind),
        .alu_fn_o (alu_fn),
        .br_fn_o  (br_fn),
        .rd_o     (rd),
        .rs1_o    (rs1),
        .rs2_o    (rs2),
        .imm_o    (imm),
        .reg_we_o (reg_we),
        .mem_we_o (mem_we),
        .mem_re_o (mem_re)
    );

    typedef struct packed {
        logic [31:0] ins;
        logic [3:0]  k;
        logic [3:0]  a;
        logic [2:0]  b;
        logic [31:0] im;
        logic [2:0]  we;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    checks   = 0;
    int    failures = 0;
    bit    done     = 0;

    function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [4:0] s2,
                                          input logic [4:0] s1, input logic [2:0] f3,
                                          input logic [4:0] d, input logic [6:0] op);
        return {f7, s2, s1, f3, d, op};
    endfunction
    function automatic logic [31:0] enc_i(input logic [31:0] v, input logic [4:0] s1,
                                          input logic [2:0] f3, input logic [4:0] d,
                                          input logic [6:0] op);
        return {v[11:0], s1, f3, d, op};
    endfunction
    function automatic logic [31:0] enc_s(input logic [31:0] v, input logic [4:0] s2,
                                          input logic [4:0] s1, input logic [2:0] f3);
        return {v[11:5], s2, s1, f3, v[4:0], 7'b0100011};
    endfunction
    function automatic logic [31:0] enc_b(input logic [31:0] v, input logic [4:0] s2,
                                          input logic [4:0] s1, input logic [2:0] f3);
        return {v[12], v[10:5], s2, s1, f3, v[4:1], v[11], 7'b1100011};
    endfunction
    function automatic logic [31:0] enc_j(input logic [31:0] v, input logic [4:0] d);
        return {v[20], v[10:1], v[11], v[19:12], d, 7'b1101111};
    endfunction
    function automatic logic [31:0] enc_u(input logic [19:0] v, input logic [4:0] d);
        return {v, d, 7'b0110111};
    endfunction

    // driver: queue the expectation, then apply the word
    task automatic drive(input string tag, input logic [31:0] ins, input logic [3:0] k,
                         input logic [3:0] a, input logic [2:0] b, input logic [31:0] im,
                         input logic [2:0] we);
        @(posedge clk);
        exp_q.push_back('{ins, k, a, b, im, we});
        tag_q.push_back(tag);
        instr = ins;
    endtask

    task automatic unsup(input string tag, input logic [31:0] ins);
        drive(tag, ins, K_UNSUP, ALU_ADD, BR_EQ, 32'h0, 3'b000);
    endtask

    // monitor: compare at the falling edge after each word is applied
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() != 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (kind !== e.k || alu_fn !== e.a || br_fn !== e.b || imm !== e.im ||
                    {reg_we, mem_we, mem_re} !== e.we) begin
                    failures++;
                    $display("FAIL %s ins=%h actual kind=%0d alu=%0d br=%0d imm=%h we=%b expected kind=%0d alu=%0d br=%0d imm=%h we=%b",
                             t, e.ins, kind, alu_fn, br_fn, imm, {reg_we, mem_we, mem_re},
                             e.k, e.a, e.b, e.im, e.we);
                end
                checks++;
                if (rd !== e.ins[11:7] || rs1 !== e.ins[19:15] || rs2 !== e.ins[24:20]) begin
                    failures++;
                    $display("FAIL R1 ins=%h actual rd/rs1/rs2=%0d/%0d/%0d expected %0d/%0d/%0d",
                             e.ins, rd, rs1, rs2, e.ins[11:7], e.ins[19:15], e.ins[24:20]);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst   = 1'b1;
        instr = 32'h0;
        // reset state: all-zero word is an unknown opcode
        unsup("R12 reset all-zero", 32'h0);
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // R3 reg-reg
        drive("R3 add", enc_r(7'h00, 5'd1, 5'd2, 3'b000, 5'd3, OPC_OP), K_OP, ALU_ADD, BR_EQ, 0, 3'b100);
        drive("R3 sub", enc_r(7'h20, 5'd31, 5'd17, 3'b000, 5'd9, OPC_OP), K_OP, ALU_SUB, BR_EQ, 0, 3'b100);
        drive("R3 sra", enc_r(7'h20, 5'd4, 5'd5, 3'b101, 5'd6, OPC_OP), K_OP, ALU_SRA, BR_EQ, 0, 3'b100);
        drive("R3 srl", enc_r(7'h00, 5'd4, 5'd5, 3'b101, 5'd6, OPC_OP), K_OP, ALU_SRL, BR_EQ, 0, 3'b100);
        drive("R3 sltu", enc_r(7'h00, 5'd8, 5'd7, 3'b011, 5'd1, OPC_OP), K_OP, ALU_SLTU, BR_EQ, 0, 3'b100);
        drive("R3 and", enc_r(7'h00, 5'd8, 5'd7, 3'b111, 5'd1, OPC_OP), K_OP, ALU_AND, BR_EQ, 0, 3'b100);
        unsup("R3 alt f7 with and", enc_r(7'h20, 5'd8, 5'd7, 3'b111, 5'd1, OPC_OP));
        unsup("R3 unknown f7", enc_r(7'h01, 5'd8, 5'd7, 3'b000, 5'd1, OPC_OP));

        // R4/R5 reg-imm
        drive("R4 addi bit30 stays add", enc_i(32'h400, 5'd2, 3'b000, 5'd3, OPC_OPIMM), K_OPIMM, ALU_ADD, BR_EQ, 32'h400, 3'b100);
        drive("R5 addi -1", enc_i(32'hFFFFFFFF, 5'd2, 3'b000, 5'd3, OPC_OPIMM), K_OPIMM, ALU_ADD, BR_EQ, 32'hFFFFFFFF, 3'b100);
        drive("R4 srai", enc_i(32'h405, 5'd2, 3'b101, 5'd3, OPC_OPIMM), K_OPIMM, ALU_SRA, BR_EQ, 32'h405, 3'b100);
        drive("R4 srli 31", enc_i(32'h01F, 5'd2, 3'b101, 5'd3, OPC_OPIMM), K_OPIMM, ALU_SRL, BR_EQ, 32'h1F, 3'b100);
        drive("R4 slli", enc_i(32'h003, 5'd2, 3'b001, 5'd3, OPC_OPIMM), K_OPIMM, ALU_SLL, BR_EQ, 32'h3, 3'b100);
        unsup("R4 slli alt f7", enc_i(32'h401, 5'd2, 3'b001, 5'd3, OPC_OPIMM));
        unsup("R4 srli bad f7", enc_i(32'h201, 5'd2, 3'b101, 5'd3, OPC_OPIMM));
        drive("R5 xori min", enc_i(32'hFFFFF800, 5'd9, 3'b100, 5'd10, OPC_OPIMM), K_OPIMM, ALU_XOR, BR_EQ, 32'hFFFFF800, 3'b100);
        drive("R5 slti max", enc_i(32'h7FF, 5'd9, 3'b010, 5'd10, OPC_OPIMM), K_OPIMM, ALU_SLT, BR_EQ, 32'h7FF, 3'b100);
        drive("R4 ori", enc_i(32'h0F0, 5'd9, 3'b110, 5'd10, OPC_OPIMM), K_OPIMM, ALU_OR, BR_EQ, 32'hF0, 3'b100);

        // R10/R11 load, store, jalr
        drive("R10 lw -4", enc_i(32'hFFFFFFFC, 5'd2, 3'b010, 5'd5, OPC_LOAD), K_LOAD, ALU_ADD, BR_EQ, 32'hFFFFFFFC, 3'b101);
        unsup("R10 lh rejected", enc_i(32'h4, 5'd2, 3'b001, 5'd5, OPC_LOAD));
        drive("R6 sw -1", enc_s(32'hFFFFFFFF, 5'd31, 5'd1, 3'b010), K_STORE, ALU_ADD, BR_EQ, 32'hFFFFFFFF, 3'b010);
        drive("R6 sw 7e5", enc_s(32'h7E5, 5'd12, 5'd13, 3'b010), K_STORE, ALU_ADD, BR_EQ, 32'h7E5, 3'b010);
        unsup("R10 sb rejected", enc_s(32'h10, 5'd12, 5'd13, 3'b000));
        drive("R10 jalr", enc_i(32'h7FF, 5'd1, 3'b000, 5'd1, OPC_JALR), K_JALR, ALU_ADD, BR_EQ, 32'h7FF, 3'b100);
        unsup("R10 jalr bad f3", enc_i(32'h7FF, 5'd1, 3'b001, 5'd1, OPC_JALR));

        // R7 branches
        drive("R7 beq min", enc_b(32'hFFFFF000, 5'd2, 5'd1, 3'b000), K_BRANCH, ALU_ADD, BR_EQ, 32'hFFFFF000, 3'b000);
        drive("R7 bne max", enc_b(32'h00000FFE, 5'd2, 5'd1, 3'b001), K_BRANCH, ALU_ADD, BR_NE, 32'hFFE, 3'b000);
        drive("R7 blt bit11", enc_b(32'h00000800, 5'd2, 5'd1, 3'b100), K_BRANCH, ALU_ADD, BR_LT, 32'h800, 3'b000);
        drive("R7 bge -2", enc_b(32'hFFFFFFFE, 5'd2, 5'd1, 3'b101), K_BRANCH, ALU_ADD, BR_GE, 32'hFFFFFFFE, 3'b000);
        drive("R7 bltu", enc_b(32'h8, 5'd3, 5'd4, 3'b110), K_BRANCH, ALU_ADD, BR_LTU, 32'h8, 3'b000);
        drive("R7 bgeu", enc_b(32'h1E, 5'd3, 5'd4, 3'b111), K_BRANCH, ALU_ADD, BR_GEU, 32'h1E, 3'b000);
        unsup("R7 f3 010 rejected", enc_b(32'h8, 5'd3, 5'd4, 3'b010));
        unsup("R7 f3 011 rejected", enc_b(32'h8, 5'd3, 5'd4, 3'b011));

        // R8 jal
        drive("R8 jal -2", enc_j(32'hFFFFFFFE, 5'd1), K_JAL, ALU_ADD, BR_EQ, 32'hFFFFFFFE, 3'b100);
        drive("R8 jal max", enc_j(32'h000FFFFE, 5'd1), K_JAL, ALU_ADD, BR_EQ, 32'h000FFFFE, 3'b100);
        drive("R8 jal bit11", enc_j(32'h00000800, 5'd0), K_JAL, ALU_ADD, BR_EQ, 32'h800, 3'b100);
        drive("R8 jal min", enc_j(32'hFFF00000, 5'd7), K_JAL, ALU_ADD, BR_EQ, 32'hFFF00000, 3'b100);

        // R9 lui
        drive("R9 lui ones", enc_u(20'hFFFFF, 5'd8), K_LUI, ALU_ADD, BR_EQ, 32'hFFFFF000, 3'b100);
        drive("R9 lui pattern", enc_u(20'h12345, 5'd8), K_LUI, ALU_ADD, BR_EQ, 32'h12345000, 3'b100);

        // R2/R12 unknown opcodes
        unsup("R2 opcode all ones", 32'hFFFFFFFF);
        unsup("R2 auipc not decoded", {20'hABCDE, 5'd3, 7'b0010111});

        wait (exp_q.size() == 0);
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule